// File: doc/BRIEF.md
# APB Transfer Failure Triage Monitor

This block is a passive observer for a shared APB bus that serves several subordinates. It drives nothing on the bus. It follows each access through its setup and access phases. Every access that fails is placed in one of three bins:

- **hang**: a liveness failure, where ready never arrives in time;
- **garbage**: a safety failure, where a read completes while the addressed subordinate's data is not yet valid;
- **error**: a failure the subordinate signals itself, by raising its error line at completion.

The result comes out as a two-bit class code that is valid during a one-cycle event pulse. The block also keeps the transfer context it captured on the first access-phase edge.

Besides the per-access verdict, the monitor keeps sticky flags for three conditions. The first is a malformed phase sequence. The second is an access held up even though the addressed subordinate's own ready is high, which means a neighbour is stalling the shared line. The third is a per-subordinate record of any unselected subordinate that drove its ready low.

These flags point a debugger at the slave that is actually responsible. This matters because a default-ready fault shows up as a hang on a different slave. The block is placed beside the bus fabric and its outputs are read by a debug or trace path.

Top module: `apbtri_monitor`

## Requirements
- R1: A verdict appears as `evt_pulse` high for exactly one cycle, registered on the clock edge that decides it. `evt_class` uses 01 for hang, 10 for garbage and 11 for error, and it reads 00 whenever `evt_pulse` is low.
- R2: The access phase begins on the first edge with a select and `bus_enable` high that does not continue an access still waiting for ready. If `bus_ready` is low on MAX_WAIT+1 consecutive access edges counted from that first edge, a hang verdict is raised on the last of those edges. If ready is high on any earlier one of those edges, no hang is raised. Once a hang has been raised, that access produces no further verdict, even when it completes later.
- R3: On a completion edge (select, enable and ready all high), a high `bus_err` gives the error verdict. `bus_err` has no effect on any other edge.
- R4: A read (`bus_write` low) that completes without error gives the garbage verdict when the selected subordinate's `slv_valid` bit is low at that edge. Writes never produce a garbage verdict, and error takes precedence over garbage.
- R5: `ctx_addr`, `ctx_write`, `ctx_strb` and `ctx_sel` take the values present on the first access-phase edge. Values from the setup cycle or from later wait cycles are not captured, and the context holds until the next access begins.
- R6: `shape_viol` sets and stays set when any of the following occurs:
  - enable is high with no select;
  - more than one select is high;
  - an access phase starts without a preceding setup cycle;
  - the cycle after a setup cycle is not an access phase with the same select;
  - an access waiting for ready loses its select or enable, or changes its select.
- R7: `nbr_fault` sets and stays set when, on an access edge with `bus_ready` low, the selected subordinate's `slv_ready` bit is high.
- R8: `dflt_viol[i]` sets and stays set on any edge where `bus_sel[i]` is low and `slv_ready[i]` is low.
- R9: A synchronous active-low reset clears the following: the event output, the context, all sticky flags and the wait counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | NSLV | One select line per subordinate |
| bus_enable | input | 1 | Access-phase enable |
| bus_write | input | 1 | High for a write transfer |
| bus_addr | input | AW | Transfer address |
| bus_strb | input | SW | Byte-lane strobes |
| bus_ready | input | 1 | Shared ready seen by the manager |
| bus_err | input | 1 | Shared subordinate error |
| slv_ready | input | NSLV | Each subordinate's own ready before merging |
| slv_valid | input | NSLV | Each subordinate's read-data-valid hint |
| evt_pulse | output | 1 | One-cycle verdict strobe |
| evt_class | output | 2 | Verdict code, valid with the strobe |
| ctx_addr | output | AW | Captured address |
| ctx_write | output | 1 | Captured write flag |
| ctx_strb | output | SW | Captured strobes |
| ctx_sel | output | NSLV | Captured select vector |
| shape_viol | output | 1 | Sticky phase-shape violation |
| nbr_fault | output | 1 | Sticky neighbour-stall flag |
| dflt_viol | output | NSLV | Sticky default-ready violation per subordinate |

## Verification
**Verdict timing.** A completion verdict becomes visible one register after the completion edge. For an access with k wait cycles, the bench therefore expects the pulse at the falling edge that follows access edge k. A hang is expected at the falling edge that follows access edge MAX_WAIT. The bench counts rising edges and compares the cycle in which the pulse was seen against this expected value.

**Flags and context.** Sticky flags and captured context change one cycle after the offending or first access edge. The bench reads them only after an idle cycle has closed the transfer.

**Sampling.** All stimulus changes on the falling edge, so the monitor's decisions are made on stable inputs.

// File: rtl/apbtri_pkg.sv
`timescale 1ns/1ps
package apbtri_pkg;
   typedef enum logic [1:0] {
      CLS_NONE = 2'b00,
      CLS_HANG = 2'b01,
      CLS_GARB = 2'b10,
      CLS_ERR  = 2'b11
   } tri_class_e;
endpackage

// File: rtl/apbtri_phase.sv
`timescale 1ns/1ps
// Tracks setup/access phases of the shared bus and flags malformed shapes.
module apbtri_phase #(
   parameter int NSLV = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSLV-1:0] sel,
   input  logic            enable,
   input  logic            ready,
   output logic            acc_now,
   output logic            acc_first,
   output logic            shape_viol
);
   logic            acc_cont_q;
   logic            setup_q;
   logic [NSLV-1:0] sel_q;
   logic            sel_any;
   logic            multi;
   logic            bad;

   assign sel_any   = |sel;
   assign multi     = |(sel & (sel - 1'b1));
   assign acc_now   = sel_any && enable;
   assign acc_first = acc_now && !acc_cont_q;

   always_comb begin
      bad = 1'b0;
      if (enable && !sel_any)                          bad = 1'b1;
      if (multi)                                       bad = 1'b1;
      if (acc_first && !setup_q)                       bad = 1'b1;
      if (setup_q && !(acc_now && sel == sel_q))       bad = 1'b1;
      if (acc_cont_q && !(acc_now && sel == sel_q))    bad = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_cont_q <= 1'b0;
         setup_q    <= 1'b0;
         sel_q      <= '0;
         shape_viol <= 1'b0;
      end else begin
         acc_cont_q <= acc_now && !ready;
         setup_q    <= sel_any && !enable;
         sel_q      <= sel;
         shape_viol <= shape_viol | bad;
      end
   end

   assert_enable_needs_select_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !(|sel)) |=> shape_viol);
   assert_shape_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      shape_viol |=> shape_viol);
endmodule

// File: rtl/apbtri_watch.sv
`timescale 1ns/1ps
// Bounded-wait watchdog and completion classifier.
module apbtri_watch
   import apbtri_pkg::*;
#(
   parameter int MAX_WAIT = 6
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       acc_now,
   input  logic       acc_first,
   input  logic       ready,
   input  logic       err,
   input  logic       write,
   input  logic       valid_sel,
   output logic       evt_pulse,
   output tri_class_e evt_class
);
   localparam int WW = $clog2(MAX_WAIT + 1);
   localparam logic [WW-1:0] WMAX = WW'(MAX_WAIT);

   generate
      if (MAX_WAIT < 1) begin : g_bad_wait
         $error("MAX_WAIT must be at least 1");
      end
   endgenerate

   logic [WW-1:0] cnt_q;
   logic [WW-1:0] cur_cnt;
   logic          hung_q;
   logic          cur_hung;
   logic          hang_hit;
   logic          done;
   tri_class_e    cls_next;

   assign cur_cnt  = acc_first ? '0 : cnt_q;
   assign cur_hung = acc_first ? 1'b0 : hung_q;
   assign hang_hit = acc_now && !ready && !cur_hung && (cur_cnt == WMAX);
   assign done     = acc_now && ready && !cur_hung;

   always_comb begin
      cls_next = CLS_NONE;
      if (hang_hit)                         cls_next = CLS_HANG;
      else if (done && err)                 cls_next = CLS_ERR;
      else if (done && !write && !valid_sel) cls_next = CLS_GARB;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         hung_q    <= 1'b0;
         evt_pulse <= 1'b0;
         evt_class <= CLS_NONE;
      end else begin
         if (!acc_now) begin
            cnt_q  <= '0;
            hung_q <= 1'b0;
         end else begin
            cnt_q  <= (!ready && cur_cnt != WMAX) ? cur_cnt + 1'b1 : cur_cnt;
            hung_q <= cur_hung | hang_hit;
         end
         evt_pulse <= (cls_next != CLS_NONE);
         evt_class <= cls_next;
      end
   end

   assert_quiet_after_hang_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_now && !acc_first && hung_q) |=> !evt_pulse);
   assert_counter_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_now && !ready && !acc_first && !hung_q && cnt_q == WMAX) |=> (evt_pulse && evt_class == CLS_HANG));
endmodule

// File: rtl/apbtri_slvchk.sv
`timescale 1ns/1ps
// Per-subordinate default-ready watch and neighbour-stall detection.
module apbtri_slvchk #(
   parameter int NSLV = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSLV-1:0] sel,
   input  logic [NSLV-1:0] slv_ready,
   input  logic            bus_ready,
   input  logic            acc_now,
   output logic            nbr_fault,
   output logic [NSLV-1:0] dflt_viol
);
   genvar gi;
   generate
      for (gi = 0; gi < NSLV; gi++) begin : g_slv
         always_ff @(posedge clk) begin
            if (!rst_n) dflt_viol[gi] <= 1'b0;
            else        dflt_viol[gi] <= dflt_viol[gi] | (!sel[gi] && !slv_ready[gi]);
         end

         assert_idle_low_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (!sel[gi] && !slv_ready[gi]) |=> dflt_viol[gi]);
         assert_dflt_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
            dflt_viol[gi] |=> dflt_viol[gi]);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) nbr_fault <= 1'b0;
      else        nbr_fault <= nbr_fault | (acc_now && !bus_ready && |(sel & slv_ready));
   end

   assert_nbr_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_now && !bus_ready && |(sel & slv_ready)) |=> nbr_fault);
endmodule

// File: rtl/apbtri_monitor.sv
`timescale 1ns/1ps
// Top: APB transfer failure triage monitor.
module apbtri_monitor
   import apbtri_pkg::*;
#(
   parameter int NSLV     = 4,
   parameter int AW       = 12,
   parameter int SW       = 4,
   parameter int MAX_WAIT = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSLV-1:0] bus_sel,
   input  logic            bus_enable,
   input  logic            bus_write,
   input  logic [AW-1:0]   bus_addr,
   input  logic [SW-1:0]   bus_strb,
   input  logic            bus_ready,
   input  logic            bus_err,
   input  logic [NSLV-1:0] slv_ready,
   input  logic [NSLV-1:0] slv_valid,
   output logic            evt_pulse,
   output logic [1:0]      evt_class,
   output logic [AW-1:0]   ctx_addr,
   output logic            ctx_write,
   output logic [SW-1:0]   ctx_strb,
   output logic [NSLV-1:0] ctx_sel,
   output logic            shape_viol,
   output logic            nbr_fault,
   output logic [NSLV-1:0] dflt_viol
);
   generate
      if (NSLV < 1 || AW < 1 || SW < 1) begin : g_bad_dims
         $error("NSLV, AW and SW must be positive");
      end
   endgenerate

   logic       acc_now;
   logic       acc_first;
   logic       valid_sel;
   tri_class_e cls;

   assign valid_sel = |(bus_sel & slv_valid);
   assign evt_class = cls;

   apbtri_phase #(.NSLV(NSLV)) u_phase (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel       (bus_sel),
      .enable    (bus_enable),
      .ready     (bus_ready),
      .acc_now   (acc_now),
      .acc_first (acc_first),
      .shape_viol(shape_viol)
   );

   apbtri_watch #(.MAX_WAIT(MAX_WAIT)) u_watch (
      .clk      (clk),
      .rst_n    (rst_n),
      .acc_now  (acc_now),
      .acc_first(acc_first),
      .ready    (bus_ready),
      .err      (bus_err),
      .write    (bus_write),
      .valid_sel(valid_sel),
      .evt_pulse(evt_pulse),
      .evt_class(cls)
   );

   apbtri_slvchk #(.NSLV(NSLV)) u_slvchk (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel      (bus_sel),
      .slv_ready(slv_ready),
      .bus_ready(bus_ready),
      .acc_now  (acc_now),
      .nbr_fault(nbr_fault),
      .dflt_viol(dflt_viol)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctx_addr  <= '0;
         ctx_write <= 1'b0;
         ctx_strb  <= '0;
         ctx_sel   <= '0;
      end else if (acc_first) begin
         ctx_addr  <= bus_addr;
         ctx_write <= bus_write;
         ctx_strb  <= bus_strb;
         ctx_sel   <= bus_sel;
      end
   end

   assert_err_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_pulse && evt_class == CLS_ERR) |-> $past(bus_err && bus_ready && bus_enable && |bus_sel));
   assert_garb_is_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_pulse && evt_class == CLS_GARB) |-> $past(!bus_write && !bus_err && bus_ready));
   assert_ctx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_now && !bus_ready && !acc_first) |=> (!acc_now || $stable(ctx_addr)));
   assert_class_qualified_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !evt_pulse |-> (evt_class == CLS_NONE));
endmodule

// File: tb/apbtri_monitor_bench.sv
`timescale 1ns/1ps
module apbtri_monitor_bench;
   localparam int NSLV = 4;
   localparam int AW   = 12;
   localparam int SW   = 4;
   localparam int MW   = 6;

   logic            clk = 1'b0;
   logic            rst_n;
   logic [NSLV-1:0] bus_sel;
   logic            bus_enable, bus_write, bus_ready, bus_err;
   logic [AW-1:0]   bus_addr;
   logic [SW-1:0]   bus_strb;
   logic [NSLV-1:0] slv_ready, slv_valid;
   logic            evt_pulse, ctx_write, shape_viol, nbr_fault;
   logic [1:0]      evt_class;
   logic [AW-1:0]   ctx_addr;
   logic [SW-1:0]   ctx_strb;
   logic [NSLV-1:0] ctx_sel, dflt_viol;

   int n_chk = 0, n_fail = 0, cyc = 0;
   int ev_n = 0, ev_cyc = 0;
   logic [1:0] ev_cls = 2'b00;

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;
   always @(negedge clk) if (evt_pulse) begin
      ev_n   = ev_n + 1;
      ev_cls = evt_class;
      ev_cyc = cyc;
   end

   apbtri_monitor #(.NSLV(NSLV), .AW(AW), .SW(SW), .MAX_WAIT(MW)) u_apbtri_monitor (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_enable(bus_enable),
      .bus_write(bus_write), .bus_addr(bus_addr), .bus_strb(bus_strb),
      .bus_ready(bus_ready), .bus_err(bus_err), .slv_ready(slv_ready),
      .slv_valid(slv_valid), .evt_pulse(evt_pulse), .evt_class(evt_class),
      .ctx_addr(ctx_addr), .ctx_write(ctx_write), .ctx_strb(ctx_strb),
      .ctx_sel(ctx_sel), .shape_viol(shape_viol), .nbr_fault(nbr_fault),
      .dflt_viol(dflt_viol));

   task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Requirement-derived verdict: R2 hang, R3 error, R4 garbage, R1 encoding
   function automatic logic [1:0] exp_cls(int waits, bit err, bit wr, bit vld);
      if (waits > MW)        return 2'b01;
      if (err)               return 2'b11;
      if (!wr && !vld)       return 2'b10;
      return 2'b00;
   endfunction

   task automatic idle();
      bus_sel = '0; bus_enable = 0; bus_ready = 1; bus_err = 0;
      slv_ready = '1; slv_valid = '0;
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 0; idle();
      bus_write = 0; bus_addr = '0; bus_strb = '0;
      @(negedge clk); @(negedge clk); rst_n = 1;
   endtask

   task automatic xfer(input int s, input bit wr, input logic [AW-1:0] a, input logic [SW-1:0] st,
                       input int waits, input bit err, input bit vld, input bit noise);
      int t0;
      logic [1:0] ec;
      @(negedge clk);
      ev_n = 0;
      bus_sel = NSLV'(1) << s; bus_enable = 0; bus_write = wr; bus_addr = a; bus_strb = st;
      bus_ready = 1; slv_ready = '1; bus_err = noise ? 1'($urandom) : 1'b0; slv_valid = '0;
      @(negedge clk);
      t0 = cyc;
      bus_enable = 1;
      bus_ready = (waits == 0); slv_ready[s] = bus_ready;
      bus_err = (waits == 0) ? err : (noise & 1'($urandom));
      slv_valid[s] = (waits == 0) ? vld : !vld;
      for (int k = 1; k <= waits; k++) begin
         @(negedge clk);
         bus_ready = (k == waits); slv_ready[s] = bus_ready;
         bus_err = (k == waits) ? err : (noise & 1'($urandom));
         slv_valid[s] = (k == waits) ? vld : !vld;
      end
      @(negedge clk); idle();
      @(negedge clk);
      ec = exp_cls(waits, err, wr, vld);
      chk("R1", "event count", 64'(ev_n), (ec == 2'b00) ? 64'd0 : 64'd1);
      if (ec != 2'b00) begin
         chk("R1", "class", 64'(ev_cls), 64'(ec));
         chk("R2", "event cycle", 64'(ev_cyc), 64'(t0 + 1 + ((waits > MW) ? MW : waits)));
      end
      chk("R5", "ctx addr", 64'(ctx_addr), 64'(a));
      chk("R5", "ctx write/strb/sel", {ctx_write, ctx_strb, ctx_sel}, {wr, st, NSLV'(1) << s});
   endtask

   initial begin
      #(4 * 150000);
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_0123));
      rst_n = 0; idle(); bus_write = 0; bus_addr = '0; bus_strb = '0;
      do_reset();
      @(negedge clk);
      chk("R9", "reset outputs",
          {evt_pulse, evt_class, ctx_addr, ctx_write, ctx_strb, ctx_sel, shape_viol, nbr_fault, dflt_viol}, '0);

      // directed corners
      xfer(0, 0, 12'h111, 4'hf, MW,     0, 1, 0);   // R2: ready on last allowed edge -> no hang
      xfer(1, 0, 12'h222, 4'h3, MW + 1, 0, 1, 0);   // R2: one edge too many -> hang
      xfer(2, 0, 12'h333, 4'h1, 2,      1, 0, 0);   // R3 over R4 precedence
      xfer(3, 1, 12'h444, 4'h8, 0,      0, 0, 0);   // R4: write never garbage
      xfer(0, 0, 12'h555, 4'h0, 3,      0, 1, 1);   // R3: err noise in waits ignored
      xfer(1, 0, 12'h666, 4'hc, 1,      0, 0, 0);   // R4: garbage read
      for (int i = 0; i < 40; i++)
         xfer($urandom_range(0, NSLV - 1), 1'($urandom), AW'($urandom), SW'($urandom),
              $urandom_range(0, MW + 2), 1'($urandom), 1'($urandom), 1'b1);
      chk("R6", "no shape flag on legal traffic", 64'(shape_viol), 64'd0);
      chk("R7", "no neighbour flag on legal traffic", 64'(nbr_fault), 64'd0);
      chk("R8", "no default-ready flag on legal traffic", 64'(dflt_viol), 64'd0);

      // R5: capture on the first access edge only
      @(negedge clk); bus_sel = 4'b0010; bus_write = 1; bus_addr = 12'hA01; bus_strb = 4'h1;
      @(negedge clk); bus_enable = 1; bus_ready = 0; slv_ready[1] = 0; bus_addr = 12'hA02; bus_strb = 4'h2;
      @(negedge clk); bus_addr = 12'hA03; bus_strb = 4'h4;
      @(negedge clk); bus_ready = 1; slv_ready[1] = 1;
      @(negedge clk); idle();
      @(negedge clk);
      chk("R5", "ctx from access edge", {ctx_addr, ctx_strb}, {12'hA02, 4'h2});

      // R7 / R8: idle neighbour 2 stalls selected slave 1
      @(negedge clk); ev_n = 0; bus_sel = 4'b0010; bus_write = 0; bus_addr = 12'h0B0;
      @(negedge clk); bus_enable = 1; slv_valid[1] = 1; slv_ready[2] = 0; bus_ready = 0;
      @(negedge clk);
      @(negedge clk); slv_ready[2] = 1; bus_ready = 1;
      @(negedge clk); idle();
      @(negedge clk);
      chk("R7", "neighbour fault", 64'(nbr_fault), 64'd1);
      chk("R8", "default-ready bits", 64'(dflt_viol), 64'h4);
      chk("R1", "no verdict for stalled valid read", 64'(ev_n), 64'd0);
      chk("R6", "stall is not a shape fault", 64'(shape_viol), 64'd0);

      // R6: enable without select
      do_reset();
      @(negedge clk); bus_enable = 1;
      @(negedge clk); idle();
      @(negedge clk);
      chk("R6", "enable without select", 64'(shape_viol), 64'd1);

      // R6: stretched setup
      do_reset();
      @(negedge clk); bus_sel = 4'b0001;
      @(negedge clk);
      @(negedge clk); bus_enable = 1;
      @(negedge clk); idle();
      @(negedge clk);
      chk("R6", "stretched setup", 64'(shape_viol), 64'd1);

      // R6: access abandoned while waiting
      do_reset();
      @(negedge clk); bus_sel = 4'b0100;
      @(negedge clk); bus_enable = 1; bus_ready = 0; slv_ready[2] = 0;
      @(negedge clk); idle();
      @(negedge clk);
      chk("R6", "abandoned access", 64'(shape_viol), 64'd1);

      // R9: reset clears sticky state and context
      do_reset();
      @(negedge clk);
      chk("R9", "reset clears flags and ctx",
          {ctx_addr, ctx_sel, shape_viol, nbr_fault, dflt_viol, evt_pulse}, '0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule